// File: doc/BRIEF.md
# Regulator Power-Up Sequencer

This block walks a multi-phase voltage regulator from off to regulating, one stage at a time. Once the enable input is high and the supply has cleared its undervoltage lockout, it waits through a fixed start delay. It then opens a short window in which the PWM outputs stay blanked so that the number of phases fitted can be detected. Next it asks the soft-start ramp to bring the output to the boot level and holds that level while the processor's voltage-ID lines settle.

After the hold it latches the ID code once and retargets the ramp to the ID level. It then waits through a masking interval and a blanking interval before power-good may assert. All long delays are counted in pulses of a slow timebase tick, and the phase-detection window is counted in clock cycles. Dropping enable or losing undervoltage clearance at any point sends the machine back to idle, with the PWM outputs blanked and power-good low on the next clock.

The DAC, the analog ramp and the window comparators are outside the block. The block sees only the ramp-finished flag (`ss_done_i`) and the output-in-range flag (`in_range_i`).

Top module: `pwrup_seq`

## Requirements
- R1: No stage advances unless both `en_i` and `uvlo_ok_i` are high. While idle: `pwm_blank_o`=1, and `phdet_win_o`, `ss_en_o`, `ss_tgt_vid_o`, `vid_strobe_o`, `pgood_o` are all 0.
- R2: The start delay begins on the clock after `en_i` and `uvlo_ok_i` are first both high. It ends on the clock edge at which the DLY_TICKS-th `tick_i` pulse is seen. Throughout it, `pwm_blank_o`=1 and `ss_en_o`=0.
- R3: The phase-detection window follows the start delay and lasts exactly PHDET_CLKS clock cycles, whatever `tick_i` does. During it, `phdet_win_o`=1, `pwm_blank_o`=1 and `ss_en_o`=0.
- R4: After the window, the boot ramp runs with `ss_en_o`=1, `ss_tgt_vid_o`=0 (0 selects boot level) and `pwm_blank_o`=0. It lasts until `ss_done_i` is seen high.
- R5: The boot hold starts on the clock after `ss_done_i` ends the boot ramp. `vid_strobe_o` rises on the edge at which the HOLD_TICKS-th tick of the hold is seen.
- R6: `vid_strobe_o` is high for exactly one cycle. On the next clock, `vid_o` takes the value `vid_i` had during the strobe cycle, and `ss_tgt_vid_o` becomes 1 (1 selects the ID level). At all other times `vid_o` holds its value.
- R7: A further MASK_TICKS + BLANK_TICKS ticks follow the edge at which `ss_done_i` ends the ID ramp. `pgood_o` stays 0 until the last of these. On that edge, `pgood_o` takes the value of `in_range_i`.
- R8: With `en_i` low at a clock edge, the machine is idle after that edge: `pgood_o`=0, `ss_en_o`=0 and `pwm_blank_o`=1.
- R9: With `uvlo_ok_i` low at a clock edge, the machine is idle after that edge. A restart runs the full start delay again.
- R10: Once blanking is over, `pgood_o` follows `in_range_i` with one register of delay. It is never 1 before blanking is over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Regulator enable |
| uvlo_ok_i | input | 1 | Supply above undervoltage lockout |
| tick_i | input | 1 | One-cycle timebase pulse for stage delays |
| ss_done_i | input | 1 | Soft-start ramp has reached its target |
| in_range_i | input | 1 | Output voltage judged in range |
| vid_i | input | VID_W | Voltage-ID code from the load |
| ss_tgt_vid_o | output | 1 | Ramp target: 0 boot level, 1 ID level |
| ss_en_o | output | 1 | Soft-start ramp enable |
| pwm_blank_o | output | 1 | Hold all PWM outputs off |
| phdet_win_o | output | 1 | Phase-detection window open |
| vid_strobe_o | output | 1 | One-cycle strobe when the ID code is latched |
| vid_o | output | VID_W | Latched ID code |
| pgood_o | output | 1 | Power-good |

## Verification
Full power-ups are run with the tick pulses placed at random, so each stage's length is judged in ticks rather than clock cycles. A phase window that counted ticks, or a delay that counted clocks, therefore shows up as a wrong count. Random waits before each ramp-done pulse show whether a ramp stage advances only on that pulse. The ID code is changed in the strobe cycle and again just after, which separates latching the right cycle from tracking the input.

Power-ups end with the in-range flag both high and low, and the flag is toggled afterwards, to separate gating power-good from holding it. Enable and lockout are withdrawn in the middle of stages. A restart is then timed to confirm the start delay runs in full again.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_DLY       = 4'd1,
        ST_PHDET     = 4'd2,
        ST_BOOT_RAMP = 4'd3,
        ST_BOOT_HOLD = 4'd4,
        ST_LATCH     = 4'd5,
        ST_VID_RAMP  = 4'd6,
        ST_MASK      = 4'd7,
        ST_BLANK     = 4'd8,
        ST_RUN       = 4'd9
    } seq_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwrup_stage_timer.sv
module pwrup_stage_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (step_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Last counted step of the stage
    assign done_o = step_i && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pwrup_stage_fsm.sv
module pwrup_stage_fsm
    import pwrup_seq_pkg::*;
#(
    parameter int unsigned VID_W       = 8,
    parameter int unsigned DLY_TICKS   = 2000,
    parameter int unsigned PHDET_CLKS  = 6,
    parameter int unsigned HOLD_TICKS  = 2000,
    parameter int unsigned MASK_TICKS  = 100,
    parameter int unsigned BLANK_TICKS = 2000,
    parameter int unsigned CNT_W       = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             uvlo_ok_i,
    input  logic             tick_i,
    input  logic             ss_done_i,
    input  logic             in_range_i,
    input  logic [VID_W-1:0] vid_i,
    input  logic             tmr_done_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             tmr_step_o,
    output seq_state_e       state_o,
    output logic             pgood_o,
    output logic [VID_W-1:0] vid_o
);

    typedef struct packed {
        seq_state_e       state;
        logic             pgood;
        logic [VID_W-1:0] vid;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      go;

    assign go = en_i && uvlo_ok_i;

    always_comb begin
        r_d = r_q;
        if (!go) begin
            r_d.state = ST_IDLE;
        end else begin
            unique case (r_q.state)
                ST_IDLE:      r_d.state = ST_DLY;
                ST_DLY:       if (tmr_done_i) r_d.state = ST_PHDET;
                ST_PHDET:     if (tmr_done_i) r_d.state = ST_BOOT_RAMP;
                ST_BOOT_RAMP: if (ss_done_i)  r_d.state = ST_BOOT_HOLD;
                ST_BOOT_HOLD: if (tmr_done_i) r_d.state = ST_LATCH;
                ST_LATCH: begin
                    r_d.state = ST_VID_RAMP;
                    r_d.vid   = vid_i;
                end
                ST_VID_RAMP:  if (ss_done_i)  r_d.state = ST_MASK;
                ST_MASK:      if (tmr_done_i) r_d.state = ST_BLANK;
                ST_BLANK:     if (tmr_done_i) r_d.state = ST_RUN;
                ST_RUN:       r_d.state = ST_RUN;
                default:      r_d.state = ST_IDLE;
            endcase
        end
        r_d.pgood = (r_d.state == ST_RUN) && in_range_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: ST_IDLE, pgood: 1'b0, vid: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // Timer is reloaded on every stage change with the new stage's length
    always_comb begin
        tmr_load_o = (r_d.state != r_q.state);
        unique case (r_d.state)
            ST_DLY:       tmr_val_o = CNT_W'(DLY_TICKS);
            ST_PHDET:     tmr_val_o = CNT_W'(PHDET_CLKS);
            ST_BOOT_HOLD: tmr_val_o = CNT_W'(HOLD_TICKS);
            ST_MASK:      tmr_val_o = CNT_W'(MASK_TICKS);
            ST_BLANK:     tmr_val_o = CNT_W'(BLANK_TICKS);
            default:      tmr_val_o = '0;
        endcase
        tmr_step_o = (r_q.state == ST_PHDET) ? 1'b1 : tick_i;
    end

    assign state_o = r_q.state;
    assign pgood_o = r_q.pgood;
    assign vid_o   = r_q.vid;

endmodule

// File: rtl/pwrup_out_decode.sv
module pwrup_out_decode
    import pwrup_seq_pkg::*;
(
    input  seq_state_e state_i,
    output logic       pwm_blank_o,
    output logic       phdet_win_o,
    output logic       ss_en_o,
    output logic       ss_tgt_vid_o,
    output logic       vid_strobe_o
);

    always_comb begin
        pwm_blank_o  = 1'b0;
        phdet_win_o  = 1'b0;
        ss_en_o      = 1'b0;
        ss_tgt_vid_o = 1'b0;
        vid_strobe_o = 1'b0;
        unique case (state_i)
            ST_IDLE, ST_DLY: pwm_blank_o = 1'b1;
            ST_PHDET: begin
                pwm_blank_o = 1'b1;
                phdet_win_o = 1'b1;
            end
            ST_BOOT_RAMP, ST_BOOT_HOLD: ss_en_o = 1'b1;
            ST_LATCH: begin
                ss_en_o      = 1'b1;
                vid_strobe_o = 1'b1;
            end
            ST_VID_RAMP, ST_MASK, ST_BLANK, ST_RUN: begin
                ss_en_o      = 1'b1;
                ss_tgt_vid_o = 1'b1;
            end
            default: pwm_blank_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_seq_pkg::*;
#(
    parameter int unsigned VID_W       = 8,
    parameter int unsigned DLY_TICKS   = 2000,
    parameter int unsigned PHDET_CLKS  = 6,
    parameter int unsigned HOLD_TICKS  = 2000,
    parameter int unsigned MASK_TICKS  = 100,
    parameter int unsigned BLANK_TICKS = 2000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             uvlo_ok_i,
    input  logic             tick_i,
    input  logic             ss_done_i,
    input  logic             in_range_i,
    input  logic [VID_W-1:0] vid_i,
    output logic             ss_tgt_vid_o,
    output logic             ss_en_o,
    output logic             pwm_blank_o,
    output logic             phdet_win_o,
    output logic             vid_strobe_o,
    output logic [VID_W-1:0] vid_o,
    output logic             pgood_o
);

    localparam int unsigned CNT_MAX = max_u(max_u(max_u(DLY_TICKS, PHDET_CLKS),
                                                  max_u(HOLD_TICKS, MASK_TICKS)),
                                            BLANK_TICKS);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_e       state;
    logic             tmr_load, tmr_step, tmr_done;
    logic [CNT_W-1:0] tmr_val;

    pwrup_stage_fsm #(
        .VID_W      (VID_W),
        .DLY_TICKS  (DLY_TICKS),
        .PHDET_CLKS (PHDET_CLKS),
        .HOLD_TICKS (HOLD_TICKS),
        .MASK_TICKS (MASK_TICKS),
        .BLANK_TICKS(BLANK_TICKS),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_i),
        .uvlo_ok_i (uvlo_ok_i),
        .tick_i    (tick_i),
        .ss_done_i (ss_done_i),
        .in_range_i(in_range_i),
        .vid_i     (vid_i),
        .tmr_done_i(tmr_done),
        .tmr_load_o(tmr_load),
        .tmr_val_o (tmr_val),
        .tmr_step_o(tmr_step),
        .state_o   (state),
        .pgood_o   (pgood_o),
        .vid_o     (vid_o)
    );

    pwrup_stage_timer #(
        .CNT_W(CNT_W)
    ) u_tmr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .step_i    (tmr_step),
        .done_o    (tmr_done)
    );

    pwrup_out_decode u_dec (
        .state_i     (state),
        .pwm_blank_o (pwm_blank_o),
        .phdet_win_o (phdet_win_o),
        .ss_en_o     (ss_en_o),
        .ss_tgt_vid_o(ss_tgt_vid_o),
        .vid_strobe_o(vid_strobe_o)
    );

endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk #(
    parameter int unsigned VID_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic             uvlo_ok_i,
    input logic             in_range_i,
    input logic [VID_W-1:0] vid_i,
    input logic             ss_tgt_vid_o,
    input logic             ss_en_o,
    input logic             pwm_blank_o,
    input logic             phdet_win_o,
    input logic             vid_strobe_o,
    input logic [VID_W-1:0] vid_o,
    input logic             pgood_o
);

    // R3
    window_blanked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phdet_win_o |-> (pwm_blank_o && !ss_en_o));

    // R8
    enable_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!pgood_o && pwm_blank_o && !ss_en_o && !phdet_win_o));

    // R9
    uvlo_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !uvlo_ok_i |=> (!pgood_o && pwm_blank_o && !ss_en_o && !phdet_win_o));

    // R10
    pgood_follows_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pgood_o |-> ($past(in_range_i) && ss_tgt_vid_o));

    // R6
    strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vid_strobe_o |=> (!vid_strobe_o && ss_tgt_vid_o && (vid_o == $past(vid_i))));

    // R6
    vid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vid_strobe_o |=> $stable(vid_o));

    // R6
    target_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ss_tgt_vid_o) |-> $past(vid_strobe_o));

endmodule

bind pwrup_seq pwrup_seq_chk #(.VID_W(VID_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .uvlo_ok_i   (uvlo_ok_i),
    .in_range_i  (in_range_i),
    .vid_i       (vid_i),
    .ss_tgt_vid_o(ss_tgt_vid_o),
    .ss_en_o     (ss_en_o),
    .pwm_blank_o (pwm_blank_o),
    .phdet_win_o (phdet_win_o),
    .vid_strobe_o(vid_strobe_o),
    .vid_o       (vid_o),
    .pgood_o     (pgood_o)
);

// File: tb/pwrup_seq_tb.sv
module pwrup_seq_tb;

    localparam int VID_W = 8;
    localparam int DLY   = 5;
    localparam int PHW   = 6;
    localparam int HOLD  = 4;
    localparam int MASK  = 3;
    localparam int BLANK = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, uvlo = 1'b0, tick = 1'b0, ss_done = 1'b0, in_range = 1'b0;
    logic [VID_W-1:0] vid = '0;
    logic tgt, ss_en, blank, phdet, strobe, pgood;
    logic [VID_W-1:0] vid_q;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwrup_seq #(
        .VID_W(VID_W), .DLY_TICKS(DLY), .PHDET_CLKS(PHW),
        .HOLD_TICKS(HOLD), .MASK_TICKS(MASK), .BLANK_TICKS(BLANK)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .uvlo_ok_i(uvlo), .tick_i(tick),
        .ss_done_i(ss_done), .in_range_i(in_range), .vid_i(vid),
        .ss_tgt_vid_o(tgt), .ss_en_o(ss_en), .pwm_blank_o(blank),
        .phdet_win_o(phdet), .vid_strobe_o(strobe), .vid_o(vid_q), .pgood_o(pgood)
    );

    function automatic bit idle_ok();
        return blank && !phdet && !ss_en && !tgt && !strobe && !pgood;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: random tick driven at the falling edge, outputs sampled 1 ns after the rising edge
    task automatic cyc(output bit tk);
        @(negedge clk);
        tick = (($urandom % 3) == 0);
        @(posedge clk);
        tk = tick;
        #1;
    endtask

    task automatic idle_cycles(input int n);
        bit tk;
        for (int i = 0; i < n; i++) cyc(tk);
    endtask

    task automatic power_up(input bit rng);
        bit tk;
        bit bad;
        int n;
        int w;
        logic [VID_W-1:0] latched;
        en = 1'b1; uvlo = 1'b1; in_range = rng;
        vid = VID_W'($urandom);
        cyc(tk);                      // idle -> start delay, tick not counted
        n = 0; bad = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            cyc(tk);
            if (tk) n++;
            if (phdet) break;
            if (!blank || ss_en) bad = 1'b1;
        end
        chk(n == DLY, "R2 start delay ticks", n, DLY);
        chk(!bad, "R2 blanked during delay", bad, 0);
        w = 1; bad = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (!blank || ss_en) bad = 1'b1;
            cyc(tk);
            if (!phdet) break;
            w++;
        end
        chk(w == PHW, "R3 window cycles", w, PHW);
        chk(!bad, "R3 window blanked", bad, 0);
        chk(ss_en && !tgt && !blank, "R4 boot ramp outputs", {ss_en, tgt, blank}, 3'b100);
        n = $urandom % 6;
        for (int i = 0; i < n; i++) cyc(tk);
        chk(ss_en && !tgt && !strobe, "R4 waits for ramp done", {ss_en, tgt, strobe}, 3'b100);
        ss_done = 1'b1; cyc(tk); ss_done = 1'b0;
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            cyc(tk);
            if (tk) n++;
            if (strobe) break;
        end
        chk(n == HOLD, "R5 hold ticks", n, HOLD);
        latched = VID_W'($urandom);
        vid = latched;
        cyc(tk);
        chk(vid_q == latched, "R6 latched code", vid_q, latched);
        chk(!strobe && tgt, "R6 strobe single, target ID", {strobe, tgt}, 2'b01);
        vid = ~latched;
        cyc(tk);
        chk(vid_q == latched, "R6 code held", vid_q, latched);
        n = $urandom % 4;
        for (int i = 0; i < n; i++) cyc(tk);
        ss_done = 1'b1; cyc(tk); ss_done = 1'b0;
        n = 0; bad = 1'b0;
        while (n < MASK + BLANK) begin
            cyc(tk);
            if (tk) n++;
            if (n < MASK + BLANK && pgood) bad = 1'b1;
        end
        chk(!bad, "R7 pgood low while masked", bad, 0);
        chk(pgood == rng, "R7 pgood at end of blanking", pgood, rng);
        in_range = !rng; cyc(tk);
        chk(pgood == !rng, "R10 pgood follows range", pgood, !rng);
        in_range = rng; cyc(tk);
        chk(pgood == rng, "R10 pgood follows range back", pgood, rng);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit tk;
        bit bad;
        void'($urandom(32'd20250611));
        repeat (3) @(posedge clk);
        #1;
        chk(idle_ok(), "R1 reset state", {blank, ss_en, pgood}, 3'b100);
        rst_n = 1'b1;
        idle_cycles(2);

        // R1: one of the two start conditions missing
        en = 1'b1; uvlo = 1'b0; bad = 1'b0;
        for (int i = 0; i < 30; i++) begin cyc(tk); if (!idle_ok()) bad = 1'b1; end
        chk(!bad, "R1 enable without uvlo clear", bad, 0);
        en = 1'b0; uvlo = 1'b1; bad = 1'b0;
        for (int i = 0; i < 30; i++) begin cyc(tk); if (!idle_ok()) bad = 1'b1; end
        chk(!bad, "R1 uvlo clear without enable", bad, 0);
        uvlo = 1'b0; idle_cycles(2);

        // Full power-up, then enable removed while regulating
        power_up(1'b1);
        en = 1'b0; cyc(tk);
        chk(!pgood && !ss_en && blank, "R8 enable drop in run", {pgood, ss_en, blank}, 3'b001);
        uvlo = 1'b0; idle_cycles(2);

        // Lockout lost during the boot ramp, then a full restart
        en = 1'b1; uvlo = 1'b1;
        for (int i = 0; i < 2000; i++) begin cyc(tk); if (ss_en) break; end
        uvlo = 1'b0; cyc(tk);
        chk(idle_ok(), "R9 uvlo loss in boot ramp", {blank, ss_en}, 2'b10);
        en = 1'b0; idle_cycles(2);
        power_up(1'b0);

        // Enable drop in the start delay
        en = 1'b0; uvlo = 1'b0; idle_cycles(2);
        en = 1'b1; uvlo = 1'b1; idle_cycles(3);
        en = 1'b0; cyc(tk);
        chk(idle_ok(), "R8 enable drop in delay", {blank, phdet}, 2'b10);
        uvlo = 1'b0; idle_cycles(2);

        // Random repeats
        for (int r = 0; r < 4; r++) begin
            power_up(bit'($urandom % 2));
            en = 1'b0; uvlo = 1'b0; cyc(tk);
            chk(idle_ok(), "R8 return to idle", {blank, pgood}, 2'b10);
            idle_cycles(1 + ($urandom % 3));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule